// File: doc/BRIEF.md
# Six-Register Ring Store with Byte Port

This block holds six field-width registers, called A through F, chained in a closed ring for an elliptic-curve datapath. Only register A can be reached from outside. Bytes are pushed into its low end or taken from its high end. An external arithmetic unit reads A, B and C as operands, and its result is always written back into A. Any other register is reached by turning the ring one step at a time, so each register needs only a small input selector.

B is one bit wider than the field. The extra bit is a scratch position for a digit-serial multiplier that lives outside this block, and it is cleared whenever B is loaded. A 3-bit command picks one action per cycle: hold, push a byte, pop a byte, rotate the ring, capture the arithmetic result, or exchange A and B.

Top module: `byte_ring_store`

## Requirements
- R1: While `rst_n` is low, every register is zero, so `opa_o`, `opb_o`, `opc_o` and `byte_o` all read zero.
- R2: Command 1 (push) shifts A left by 8 bits, places `byte_i` in A[7:0] and drops A's top 8 bits. After 21 pushes, A holds the low 163 bits of the 168-bit concatenation of those bytes, first byte most significant.
- R3: `byte_o` always shows A[162:155]. Command 2 (pop) shifts A left by 8 bits and fills A[7:0] with zeros.
- R4: Command 3 (rotate) moves each register into the next one in one cycle. A takes F. B takes {0, A}. C takes B[162:0]. D takes C, E takes D and F takes E.
- R5: Command 4 (capture) loads `alu_i` into A.
- R6: Command 5 (exchange) loads B[162:0] into A and {0, A} into B in the same cycle.
- R7: Commands 0, 6 and 7 leave all six registers unchanged.
- R8: Commands 1, 2 and 4 change only A. B through F keep their values.
- R9: `opa_o`, `opb_o` and `opc_o` always show the current contents of A, B (all 164 bits) and C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Command code for this cycle |
| byte_i | input | 8 | Byte pushed into the low end of A |
| alu_i | input | 163 | Arithmetic result, captured into A |
| byte_o | output | 8 | Top byte of A |
| opa_o | output | 163 | Register A |
| opb_o | output | 164 | Register B, including the scratch bit |
| opc_o | output | 163 | Register C |

## Verification
The bench runs through every 3-bit command code several times over, with fresh pseudo-random field values and bytes each time. A reference model is computed from the requirements, and after every cycle it is compared with A, B, C and the output byte. Running the unused codes 6 and 7 against random contents separates a true hold from a decode that slips into a neighbouring command. Exchanges are interleaved with rotations, which exposes a wrong direction of travel or a scratch bit that is not cleared. A 21-byte push shows the exact truncation at the top of A. Each sweep ends with six rotations, which bring D, E and F out to the operand ports so they can be checked.

// File: rtl/byte_ring_pkg.sv
package byte_ring_pkg;
    typedef enum logic [2:0] {
        CMD_HOLD  = 3'd0,
        CMD_PUSH  = 3'd1,
        CMD_POP   = 3'd2,
        CMD_ROT   = 3'd3,
        CMD_ALU   = 3'd4,
        CMD_XCHG  = 3'd5
    } ring_cmd_e;
endpackage

// File: rtl/ring_head_next.sv
module ring_head_next
    import byte_ring_pkg::*;
#(
    parameter int FIELD_W = 163,
    parameter int BYTE_W  = 8
) (
    input  ring_cmd_e          cmd,
    input  logic [FIELD_W-1:0] head_q,
    input  logic [FIELD_W-1:0] second_low,
    input  logic [FIELD_W-1:0] last_q,
    input  logic [FIELD_W-1:0] alu_res,
    input  logic [BYTE_W-1:0]  byte_in,
    output logic [FIELD_W-1:0] head_d
);
    localparam int KEEP_W = FIELD_W - BYTE_W;

    always_comb begin
        case (cmd)
            CMD_PUSH: head_d = {head_q[KEEP_W-1:0], byte_in};
            CMD_POP:  head_d = {head_q[KEEP_W-1:0], {BYTE_W{1'b0}}};
            CMD_ROT:  head_d = last_q;
            CMD_ALU:  head_d = alu_res;
            CMD_XCHG: head_d = second_low;
            default:  head_d = head_q;
        endcase
    end
endmodule

// File: rtl/ring_second_next.sv
module ring_second_next
    import byte_ring_pkg::*;
#(
    parameter int FIELD_W = 163
) (
    input  ring_cmd_e          cmd,
    input  logic [FIELD_W-1:0] head_q,
    input  logic [FIELD_W:0]   second_q,
    output logic [FIELD_W:0]   second_d
);
    always_comb begin
        case (cmd)
            CMD_ROT, CMD_XCHG: second_d = {1'b0, head_q};
            default:           second_d = second_q;
        endcase
    end
endmodule

// File: rtl/ring_tail_stage.sv
module ring_tail_stage #(
    parameter int W = 163
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] prev_q,
    output logic [W-1:0] stage_q
);
    logic [W-1:0] stage_d;

    always_comb begin
        stage_d = adv ? prev_q : stage_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end
endmodule

// File: rtl/byte_ring_store.sv
module byte_ring_store
    import byte_ring_pkg::*;
#(
    parameter int FIELD_W  = 163,
    parameter int BYTE_W   = 8,
    parameter int NUM_REGS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op_i,
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic [FIELD_W-1:0] alu_i,
    output logic [BYTE_W-1:0]  byte_o,
    output logic [FIELD_W-1:0] opa_o,
    output logic [FIELD_W:0]   opb_o,
    output logic [FIELD_W-1:0] opc_o
);
    localparam int NUM_TAIL = NUM_REGS - 2;
    localparam int B_W      = FIELD_W + 1;

    typedef struct packed {
        logic [FIELD_W-1:0] a;
        logic [B_W-1:0]     b;
    } head_t;

    ring_cmd_e          cmd;
    head_t              st_d, st_q;
    logic [FIELD_W-1:0] a_nx;
    logic [B_W-1:0]     b_nx;
    logic [FIELD_W-1:0] tail_q [NUM_TAIL];
    logic               rot_en;

    assign cmd    = ring_cmd_e'(op_i);
    assign rot_en = (cmd == CMD_ROT);

    ring_head_next #(.FIELD_W(FIELD_W), .BYTE_W(BYTE_W)) u_head (
        .cmd        (cmd),
        .head_q     (st_q.a),
        .second_low (st_q.b[FIELD_W-1:0]),
        .last_q     (tail_q[NUM_TAIL-1]),
        .alu_res    (alu_i),
        .byte_in    (byte_i),
        .head_d     (a_nx)
    );

    ring_second_next #(.FIELD_W(FIELD_W)) u_second (
        .cmd      (cmd),
        .head_q   (st_q.a),
        .second_q (st_q.b),
        .second_d (b_nx)
    );

    generate
        for (genvar k = 0; k < NUM_TAIL; k++) begin : g_tail
            if (k == 0) begin : g_first
                ring_tail_stage #(.W(FIELD_W)) u_stage (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .adv     (rot_en),
                    .prev_q  (st_q.b[FIELD_W-1:0]),
                    .stage_q (tail_q[k])
                );
            end else begin : g_rest
                ring_tail_stage #(.W(FIELD_W)) u_stage (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .adv     (rot_en),
                    .prev_q  (tail_q[k-1]),
                    .stage_q (tail_q[k])
                );
            end
        end
    endgenerate

    always_comb begin
        st_d   = st_q;
        st_d.a = a_nx;
        st_d.b = b_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o = st_q.a[FIELD_W-1 -: BYTE_W];
    assign opa_o  = st_q.a;
    assign opb_o  = st_q.b;
    assign opc_o  = tail_q[0];

    // R2
    push_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |=> (opa_o == {$past(opa_o[FIELD_W-BYTE_W-1:0]), $past(byte_i)}));

    // R3
    pop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2) |=> (opa_o[BYTE_W-1:0] == '0));

    // R4
    ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> (opa_o == $past(tail_q[NUM_TAIL-1]))
                         && (opb_o == {1'b0, $past(opa_o)})
                         && (opc_o == $past(opb_o[FIELD_W-1:0])));

    // R5
    alu_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> (opa_o == $past(alu_i)));

    // R6
    xchg_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) |=> (opa_o == $past(opb_o[FIELD_W-1:0]))
                         && (opb_o == {1'b0, $past(opa_o)}));

    // R7
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 || op_i == 3'd6 || op_i == 3'd7)
        |=> $stable(opa_o) && $stable(opb_o) && $stable(tail_q[0])
            && $stable(tail_q[NUM_TAIL-1]));

    // R8
    tail_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 || op_i == 3'd2 || op_i == 3'd4)
        |=> $stable(opb_o) && $stable(opc_o) && $stable(tail_q[NUM_TAIL-1]));
endmodule

// File: tb/sim_byte_ring_store.sv
module sim_byte_ring_store;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 163;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_i = 3'd0;
    logic [BW-1:0] byte_i = '0;
    logic [FW-1:0] alu_i = '0;
    logic [BW-1:0] byte_o;
    logic [FW-1:0] opa_o;
    logic [FW:0]   opb_o;
    logic [FW-1:0] opc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [FW:0] m [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_ring_store u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .byte_i(byte_i),
        .alu_i(alu_i), .byte_o(byte_o), .opa_o(opa_o), .opb_o(opb_o), .opc_o(opc_o)
    );

    function automatic logic [FW-1:0] rnd_field();
        logic [191:0] r;
        r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return r[FW-1:0];
    endfunction

    task automatic check(input string tag, input logic [FW:0] act, input logic [FW:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input logic [2:0] op);
        string ta, tb;
        case (op)
            3'd1: ta = "R2";
            3'd2: ta = "R3";
            3'd3: ta = "R4";
            3'd4: ta = "R5";
            3'd5: ta = "R6";
            default: ta = "R7";
        endcase
        tb = (op == 3'd1 || op == 3'd2 || op == 3'd4) ? "R8" : ta;
        check({ta, " opa"}, {1'b0, opa_o}, {1'b0, m[0][FW-1:0]});
        check({tb, " opb R9"}, opb_o, m[1]);
        check({tb, " opc R9"}, {1'b0, opc_o}, {1'b0, m[2][FW-1:0]});
        check("R3 byte_o", {{(FW+1-BW){1'b0}}, byte_o}, {{(FW+1-BW){1'b0}}, m[0][FW-1 -: BW]});
    endtask

    task automatic apply(input logic [2:0] op, input logic [BW-1:0] bv, input logic [FW-1:0] av);
        logic [FW:0] n [6];
        @(negedge clk);
        op_i = op; byte_i = bv; alu_i = av;
        for (int k = 0; k < 6; k++) n[k] = m[k];
        case (op)
            3'd1: n[0] = {1'b0, m[0][FW-BW-1:0], bv};
            3'd2: n[0] = {1'b0, m[0][FW-BW-1:0], {BW{1'b0}}};
            3'd3: begin
                n[0] = {1'b0, m[5][FW-1:0]};
                n[1] = {1'b0, m[0][FW-1:0]};
                n[2] = {1'b0, m[1][FW-1:0]};
                n[3] = m[2]; n[4] = m[3]; n[5] = m[4];
            end
            3'd4: n[0] = {1'b0, av};
            3'd5: begin
                n[0] = {1'b0, m[1][FW-1:0]};
                n[1] = {1'b0, m[0][FW-1:0]};
            end
            default: ;
        endcase
        @(posedge clk);
        #1;
        for (int k = 0; k < 6; k++) m[k] = n[k];
        compare_all(op);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [167:0] img;
        for (int k = 0; k < 6; k++) m[k] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: everything reads zero during reset
        check("R1 opa", {1'b0, opa_o}, '0);
        check("R1 opb", opb_o, '0);
        check("R1 opc", {1'b0, opc_o}, '0);
        check("R1 byte_o", {{(FW+1-BW){1'b0}}, byte_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: 21 pushes give the low 163 bits of the 168-bit image
        img = '0;
        for (int i = 0; i < 21; i++) begin
            logic [7:0] bv;
            bv = 8'(8'hA5 ^ (i * 37));
            img = {img[159:0], bv};
            apply(3'd1, bv, '0);
        end
        check("R2 full load", {1'b0, opa_o}, {1'b0, img[FW-1:0]});

        // R5 then R3: capture a value and drain it byte by byte
        apply(3'd4, '0, rnd_field());
        for (int i = 0; i < 21; i++) apply(3'd2, '0, '0);
        check("R3 drained", {1'b0, opa_o}, '0);

        // Sweep: every command code, repeated with fresh data
        for (int r = 0; r < 40; r++) begin
            for (int c = 0; c < 8; c++) begin
                apply(3'd4, '0, rnd_field());
                apply(3'(c), 8'($urandom), rnd_field());
                apply(3'd3, '0, '0);
            end
            // R4: bring D, E and F to the ports
            for (int k = 0; k < 6; k++) apply(3'd3, '0, '0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule